// File: doc/BRIEF.md
# Trap Entry and Delegation Sequencer

This block decides where a reported exception or interrupt is taken and produces, in one clock edge, every architectural write that trap entry needs. On each cycle in which `trapValid` is high it examines the cause word, the current privilege, both delegation masks and the debug-control state. It then picks one of four outcomes. The first is entry into debug mode on an enabled breakpoint. The second is a plain redirect to the debug exception handler while the hart is already in debug mode. The third is a trap delegated to supervisor mode, and the fourth is a trap to machine mode.

Results leave the block as registered write strobes with their data, one cycle after the trap pulse. The surrounding core applies them to its program counter, privilege, status register and per-mode trap registers. For normal traps the block stacks the interrupt-enable bit of the mode that was running into the target mode's previous-enable bit and records the old privilege. It also raises a strobe that drops any outstanding load reservation.

Privilege encoding: user 0, supervisor 1, hypervisor 2, machine 3. The status register keeps each mode's interrupt enable at the bit equal to its privilege number, so supervisor enable is bit 1 and machine enable is bit 3. The supervisor previous-enable bit is bit 5, the machine previous-enable bit is bit 7, the one-bit supervisor previous-privilege field is bit 8, and the two-bit machine previous-privilege field is bits 12:11.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset every write strobe (`pcWe`, `privWe`, `statusWe`, `sTrapWe`, `sBadWe`, `mTrapWe`, `mBadWe`, `dbgEntryWe`, `resvClear`) is low until a trap is reported.
- R2: A trap whose cause word equals `BKPT_CAUSE` while `bkptEnable[curPriv]` is set enters debug mode. Debug entry sets the debug cause to `SWBP_CODE`, saves `curPriv` to `dbgPrivOut` and `trapPc` to `dpcOut`, and loads `DBG_ROM_START` as the next PC with machine privilege. It writes no status, no supervisor or machine trap register, and no reservation clear.
- R3: A breakpoint cause whose enable bit for the current privilege is clear is handled as an ordinary trap.
- R4: When `dbgCauseIn` is nonzero and R2 does not apply, the only effect is `pcWe` with `pcNext` = `DBG_ROM_EXC`; all other strobes stay low.
- R5: A cause with bit XLEN-1 set is an interrupt: it looks up `intDeleg` at its cause number with that bit removed. Any other cause looks up `excDeleg`.
- R6: A trap goes to supervisor only if `curPriv` is 0 or 1, the cause number is below XLEN, and the selected delegation bit is set; otherwise it goes to machine.
- R7: A supervisor trap gives `pcNext` = `sVector`, `privNext` = 1, `sCauseOut` = the cause word and `sEpcOut` = `trapPc`.
- R8: The bad-address register of the chosen mode is written (`sBadWe`/`mBadWe` with `badAddr`) only when `badAddrValid` is high.
- R9: A supervisor trap writes status with bit 5 = old `status[curPriv]`, bit 8 = `curPriv[0]` and bit 1 cleared, all other bits unchanged.
- R10: A machine trap gives `pcNext` = `mVector`, `privNext` = 3, `mCauseOut` and `mEpcOut`. It writes status with bit 7 = old `status[curPriv]`, bits 12:11 = `curPriv` and bit 3 cleared, all other bits unchanged.
- R11: `resvClear` pulses on every supervisor or machine trap and never on the debug outcomes.
- R12: All outputs of a trap appear on the cycle after the `trapValid` cycle, and every strobe lasts one cycle; without `trapValid` no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | One-cycle trap report |
| trapCause | input | XLEN | Cause word, top bit marks an interrupt |
| trapPc | input | XLEN | PC of the trapping instruction |
| badAddr | input | XLEN | Faulting address |
| badAddrValid | input | 1 | `badAddr` accompanies this trap |
| curPriv | input | 2 | Current privilege |
| status | input | XLEN | Current status register |
| excDeleg | input | XLEN | Exception delegation mask |
| intDeleg | input | XLEN | Interrupt delegation mask |
| sVector | input | XLEN | Supervisor trap vector |
| mVector | input | XLEN | Machine trap vector |
| dbgCauseIn | input | 3 | Current debug cause, nonzero while in debug mode |
| bkptEnable | input | 4 | Breakpoint-to-debug enable per privilege |
| pcWe | output | 1 | Write next PC |
| pcNext | output | XLEN | Next PC |
| privWe | output | 1 | Write privilege |
| privNext | output | 2 | New privilege |
| statusWe | output | 1 | Write status |
| statusNext | output | XLEN | New status |
| sTrapWe | output | 1 | Write supervisor cause and exception PC |
| sCauseOut | output | XLEN | Supervisor cause |
| sEpcOut | output | XLEN | Supervisor exception PC |
| sBadWe | output | 1 | Write supervisor bad address |
| sBadOut | output | XLEN | Supervisor bad address |
| mTrapWe | output | 1 | Write machine cause and exception PC |
| mCauseOut | output | XLEN | Machine cause |
| mEpcOut | output | XLEN | Machine exception PC |
| mBadWe | output | 1 | Write machine bad address |
| mBadOut | output | XLEN | Machine bad address |
| dbgEntryWe | output | 1 | Write debug cause, privilege and PC |
| dbgCauseOut | output | 3 | New debug cause |
| dbgPrivOut | output | 2 | Saved privilege |
| dpcOut | output | XLEN | Saved debug PC |
| resvClear | output | 1 | Drop load reservation |

## Verification
The bench builds the block with XLEN = 16. This keeps the delegation masks small enough to write as distinct bit patterns. It also lets a sweep of cause numbers 0 to 19 step past XLEN, which exercises the out-of-range rule of R6 for both exceptions and interrupts. Every privilege, both cause kinds, four mask pairings and both bad-address states are crossed. A second sweep covers all 16 breakpoint-enable patterns against every privilege, both inside and outside debug mode.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // status field positions decoded by the rest of the core
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam int DBG_CAUSE_W = 3;

  typedef struct packed {
    logic takeDbg;
    logic redirDbg;
    logic takeSuper;
    logic takeMachine;
    logic writeBad;
  } trap_ctl_t;

endpackage

// File: rtl/trap_route_ctl.sv
module trap_route_ctl
  import trap_seq_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int BKPT_CAUSE = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   trapValid,
  input  logic [XLEN-1:0]        trapCause,
  input  logic [1:0]             curPriv,
  input  logic [XLEN-1:0]        excDeleg,
  input  logic [XLEN-1:0]        intDeleg,
  input  logic [DBG_CAUSE_W-1:0] dbgCauseIn,
  input  logic [3:0]             bkptEnable,
  input  logic                   badAddrValid,
  output trap_ctl_t              ctl
);
  localparam int IDXW = $clog2(XLEN);

  logic            isIntr;
  logic [XLEN-1:0] causeNum;
  logic [XLEN-1:0] delegMask;
  logic            inRange;
  logic            delegBit;
  logic            lowPriv;
  logic            bkptHit;
  logic            inDebug;
  logic            toSuper;

  always_comb begin
    isIntr    = trapCause[XLEN-1];
    causeNum  = {1'b0, trapCause[XLEN-2:0]};
    delegMask = isIntr ? intDeleg : excDeleg;
    inRange   = causeNum < XLEN;
    delegBit  = inRange && delegMask[causeNum[IDXW-1:0]];
    lowPriv   = curPriv <= PRIV_S;
    bkptHit   = (trapCause == XLEN'(BKPT_CAUSE)) && bkptEnable[curPriv];
    inDebug   = |dbgCauseIn;
    toSuper   = lowPriv && delegBit;

    ctl.takeDbg     = trapValid && bkptHit;
    ctl.redirDbg    = trapValid && !bkptHit && inDebug;
    ctl.takeSuper   = trapValid && !bkptHit && !inDebug && toSuper;
    ctl.takeMachine = trapValid && !bkptHit && !inDebug && !toSuper;
    ctl.writeBad    = badAddrValid;
  end

  // R6: at most one route per cycle
  a_r6_one_route: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.takeDbg, ctl.redirDbg, ctl.takeSuper, ctl.takeMachine}));

  // R6: hypervisor or machine privilege never delegates
  a_r6_high_priv_machine: assert property (@(posedge clk) disable iff (!rstN)
    curPriv[1] |-> !ctl.takeSuper);

  // R12: no route without a trap report
  a_r12_idle_no_route: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> !(ctl.takeDbg || ctl.redirDbg || ctl.takeSuper || ctl.takeMachine));

endmodule

// File: rtl/trap_state_dp.sv
module trap_state_dp
  import trap_seq_pkg::*;
#(
  parameter int              XLEN          = 64,
  parameter int              SWBP_CODE     = 1,
  parameter logic [XLEN-1:0] DBG_ROM_START = XLEN'(32'h800),
  parameter logic [XLEN-1:0] DBG_ROM_EXC   = XLEN'(32'h808)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  trap_ctl_t              ctl,
  input  logic [XLEN-1:0]        trapCause,
  input  logic [XLEN-1:0]        trapPc,
  input  logic [XLEN-1:0]        badAddr,
  input  logic [1:0]             curPriv,
  input  logic [XLEN-1:0]        status,
  input  logic [XLEN-1:0]        sVector,
  input  logic [XLEN-1:0]        mVector,
  output logic                   pcWe,
  output logic [XLEN-1:0]        pcNext,
  output logic                   privWe,
  output logic [1:0]             privNext,
  output logic                   statusWe,
  output logic [XLEN-1:0]        statusNext,
  output logic                   sTrapWe,
  output logic [XLEN-1:0]        sCauseOut,
  output logic [XLEN-1:0]        sEpcOut,
  output logic                   sBadWe,
  output logic [XLEN-1:0]        sBadOut,
  output logic                   mTrapWe,
  output logic [XLEN-1:0]        mCauseOut,
  output logic [XLEN-1:0]        mEpcOut,
  output logic                   mBadWe,
  output logic [XLEN-1:0]        mBadOut,
  output logic                   dbgEntryWe,
  output logic [DBG_CAUSE_W-1:0] dbgCauseOut,
  output logic [1:0]             dbgPrivOut,
  output logic [XLEN-1:0]        dpcOut,
  output logic                   resvClear
);
  logic            anyTrap;
  logic            oldIe;
  logic [XLEN-1:0] stackSuper;
  logic [XLEN-1:0] stackMachine;

  always_comb begin
    anyTrap = ctl.takeDbg || ctl.redirDbg || ctl.takeSuper || ctl.takeMachine;
    oldIe   = status[curPriv];

    stackSuper          = status;
    stackSuper[ST_SPIE] = oldIe;
    stackSuper[ST_SPP]  = curPriv[0];
    stackSuper[ST_SIE]  = 1'b0;

    stackMachine                 = status;
    stackMachine[ST_MPIE]        = oldIe;
    stackMachine[ST_MPP +: 2]    = curPriv;
    stackMachine[ST_MIE]         = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcWe <= 1'b0; privWe <= 1'b0; statusWe <= 1'b0;
      sTrapWe <= 1'b0; sBadWe <= 1'b0; mTrapWe <= 1'b0; mBadWe <= 1'b0;
      dbgEntryWe <= 1'b0; resvClear <= 1'b0;
      pcNext <= '0; privNext <= PRIV_M; statusNext <= '0;
      sCauseOut <= '0; sEpcOut <= '0; sBadOut <= '0;
      mCauseOut <= '0; mEpcOut <= '0; mBadOut <= '0;
      dbgCauseOut <= '0; dbgPrivOut <= PRIV_U; dpcOut <= '0;
    end else begin
      pcWe       <= anyTrap;
      privWe     <= ctl.takeDbg || ctl.takeSuper || ctl.takeMachine;
      statusWe   <= ctl.takeSuper || ctl.takeMachine;
      sTrapWe    <= ctl.takeSuper;
      sBadWe     <= ctl.takeSuper && ctl.writeBad;
      mTrapWe    <= ctl.takeMachine;
      mBadWe     <= ctl.takeMachine && ctl.writeBad;
      dbgEntryWe <= ctl.takeDbg;
      resvClear  <= ctl.takeSuper || ctl.takeMachine;

      if (ctl.takeDbg) begin
        pcNext      <= DBG_ROM_START;
        privNext    <= PRIV_M;
        dbgCauseOut <= DBG_CAUSE_W'(SWBP_CODE);
        dbgPrivOut  <= curPriv;
        dpcOut      <= trapPc;
      end
      if (ctl.redirDbg) pcNext <= DBG_ROM_EXC;
      if (ctl.takeSuper) begin
        pcNext     <= sVector;
        privNext   <= PRIV_S;
        statusNext <= stackSuper;
        sCauseOut  <= trapCause;
        sEpcOut    <= trapPc;
        if (ctl.writeBad) sBadOut <= badAddr;
      end
      if (ctl.takeMachine) begin
        pcNext     <= mVector;
        privNext   <= PRIV_M;
        statusNext <= stackMachine;
        mCauseOut  <= trapCause;
        mEpcOut    <= trapPc;
        if (ctl.writeBad) mBadOut <= badAddr;
      end
    end
  end

  a_r12_pc_follows_trap: assert property (@(posedge clk) disable iff (!rstN)
    anyTrap |=> pcWe);
  a_r12_no_spurious_pc: assert property (@(posedge clk) disable iff (!rstN)
    !anyTrap |=> !pcWe);
  a_r2_debug_entry_only: assert property (@(posedge clk) disable iff (!rstN)
    dbgEntryWe |-> (privNext == PRIV_M) && !statusWe && !resvClear && (pcNext == DBG_ROM_START));
  a_r4_redirect_only: assert property (@(posedge clk) disable iff (!rstN)
    ctl.redirDbg |=> pcWe && (pcNext == DBG_ROM_EXC) && !privWe && !statusWe);
  a_r8_sbad_in_strap: assert property (@(posedge clk) disable iff (!rstN)
    sBadWe |-> sTrapWe);
  a_r8_mbad_in_mtrap: assert property (@(posedge clk) disable iff (!rstN)
    mBadWe |-> mTrapWe);
  a_r9_sie_cleared: assert property (@(posedge clk) disable iff (!rstN)
    sTrapWe |-> !statusNext[ST_SIE] && (privNext == PRIV_S) && statusWe);
  a_r10_mie_cleared: assert property (@(posedge clk) disable iff (!rstN)
    mTrapWe |-> !statusNext[ST_MIE] && (privNext == PRIV_M) && statusWe);
  a_r11_resv_with_status: assert property (@(posedge clk) disable iff (!rstN)
    resvClear |-> statusWe && (sTrapWe || mTrapWe));

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int              XLEN          = 64,
  parameter int              BKPT_CAUSE    = 3,
  parameter int              SWBP_CODE     = 1,
  parameter logic [XLEN-1:0] DBG_ROM_START = XLEN'(32'h800),
  parameter logic [XLEN-1:0] DBG_ROM_EXC   = XLEN'(32'h808)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   trapValid,
  input  logic [XLEN-1:0]        trapCause,
  input  logic [XLEN-1:0]        trapPc,
  input  logic [XLEN-1:0]        badAddr,
  input  logic                   badAddrValid,
  input  logic [1:0]             curPriv,
  input  logic [XLEN-1:0]        status,
  input  logic [XLEN-1:0]        excDeleg,
  input  logic [XLEN-1:0]        intDeleg,
  input  logic [XLEN-1:0]        sVector,
  input  logic [XLEN-1:0]        mVector,
  input  logic [DBG_CAUSE_W-1:0] dbgCauseIn,
  input  logic [3:0]             bkptEnable,
  output logic                   pcWe,
  output logic [XLEN-1:0]        pcNext,
  output logic                   privWe,
  output logic [1:0]             privNext,
  output logic                   statusWe,
  output logic [XLEN-1:0]        statusNext,
  output logic                   sTrapWe,
  output logic [XLEN-1:0]        sCauseOut,
  output logic [XLEN-1:0]        sEpcOut,
  output logic                   sBadWe,
  output logic [XLEN-1:0]        sBadOut,
  output logic                   mTrapWe,
  output logic [XLEN-1:0]        mCauseOut,
  output logic [XLEN-1:0]        mEpcOut,
  output logic                   mBadWe,
  output logic [XLEN-1:0]        mBadOut,
  output logic                   dbgEntryWe,
  output logic [DBG_CAUSE_W-1:0] dbgCauseOut,
  output logic [1:0]             dbgPrivOut,
  output logic [XLEN-1:0]        dpcOut,
  output logic                   resvClear
);
  trap_ctl_t ctl;

  trap_route_ctl #(.XLEN(XLEN), .BKPT_CAUSE(BKPT_CAUSE)) u_ctl (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapCause(trapCause),
    .curPriv(curPriv), .excDeleg(excDeleg), .intDeleg(intDeleg),
    .dbgCauseIn(dbgCauseIn), .bkptEnable(bkptEnable),
    .badAddrValid(badAddrValid), .ctl(ctl)
  );

  trap_state_dp #(
    .XLEN(XLEN), .SWBP_CODE(SWBP_CODE),
    .DBG_ROM_START(DBG_ROM_START), .DBG_ROM_EXC(DBG_ROM_EXC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .trapCause(trapCause), .trapPc(trapPc),
    .badAddr(badAddr), .curPriv(curPriv), .status(status),
    .sVector(sVector), .mVector(mVector),
    .pcWe(pcWe), .pcNext(pcNext), .privWe(privWe), .privNext(privNext),
    .statusWe(statusWe), .statusNext(statusNext),
    .sTrapWe(sTrapWe), .sCauseOut(sCauseOut), .sEpcOut(sEpcOut),
    .sBadWe(sBadWe), .sBadOut(sBadOut),
    .mTrapWe(mTrapWe), .mCauseOut(mCauseOut), .mEpcOut(mEpcOut),
    .mBadWe(mBadWe), .mBadOut(mBadOut),
    .dbgEntryWe(dbgEntryWe), .dbgCauseOut(dbgCauseOut),
    .dbgPrivOut(dbgPrivOut), .dpcOut(dpcOut), .resvClear(resvClear)
  );

endmodule

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  localparam int XL = 16;
  localparam logic [15:0] DSTART = 16'h0800;
  localparam logic [15:0] DEXC   = 16'h0808;
  localparam logic [15:0] SVEC   = 16'h4100;
  localparam logic [15:0] MVEC   = 16'h8200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapValid = 1'b0;
  logic [15:0] trapCause = '0, trapPc = '0, badAddr = '0, status = '0;
  logic [15:0] excDeleg = '0, intDeleg = '0;
  logic [15:0] sVector = SVEC, mVector = MVEC;
  logic badAddrValid = 1'b0;
  logic [1:0] curPriv = '0;
  logic [2:0] dbgCauseIn = '0;
  logic [3:0] bkptEnable = '0;

  logic pcWe, privWe, statusWe, sTrapWe, sBadWe, mTrapWe, mBadWe, dbgEntryWe, resvClear;
  logic [15:0] pcNext, statusNext, sCauseOut, sEpcOut, sBadOut, mCauseOut, mEpcOut, mBadOut, dpcOut;
  logic [1:0] privNext, dbgPrivOut;
  logic [2:0] dbgCauseOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  trap_entry_seq #(.XLEN(XL), .BKPT_CAUSE(3), .SWBP_CODE(1),
                   .DBG_ROM_START(DSTART), .DBG_ROM_EXC(DEXC)) u_dut (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapCause(trapCause),
    .trapPc(trapPc), .badAddr(badAddr), .badAddrValid(badAddrValid),
    .curPriv(curPriv), .status(status), .excDeleg(excDeleg), .intDeleg(intDeleg),
    .sVector(sVector), .mVector(mVector), .dbgCauseIn(dbgCauseIn),
    .bkptEnable(bkptEnable), .pcWe(pcWe), .pcNext(pcNext), .privWe(privWe),
    .privNext(privNext), .statusWe(statusWe), .statusNext(statusNext),
    .sTrapWe(sTrapWe), .sCauseOut(sCauseOut), .sEpcOut(sEpcOut),
    .sBadWe(sBadWe), .sBadOut(sBadOut), .mTrapWe(mTrapWe), .mCauseOut(mCauseOut),
    .mEpcOut(mEpcOut), .mBadWe(mBadWe), .mBadOut(mBadOut),
    .dbgEntryWe(dbgEntryWe), .dbgCauseOut(dbgCauseOut), .dbgPrivOut(dbgPrivOut),
    .dpcOut(dpcOut), .resvClear(resvClear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] strobes();
    return {pcWe, privWe, statusWe, sTrapWe, sBadWe, mTrapWe, mBadWe, dbgEntryWe, resvClear};
  endfunction

  function automatic logic [15:0] expStack(logic [15:0] st, logic [1:0] p, bit toS);
    logic [15:0] r = st;
    if (toS) begin r[5] = st[p]; r[8] = p[0]; r[1] = 1'b0; end
    else begin r[7] = st[p]; r[12:11] = p; r[3] = 1'b0; end
    return r;
  endfunction

  // one trap pulse; returns at the negedge after the committing edge
  task automatic fire(input logic [15:0] c, input logic [15:0] pc, input logic [15:0] ba,
                      input logic bv, input logic [1:0] p, input logic [15:0] st,
                      input logic [15:0] exm, input logic [15:0] inm,
                      input logic [3:0] en, input logic [2:0] dc);
    @(negedge clk);
    chk("R12 idle strobes", 32'(strobes()), 32'h0);
    trapCause = c; trapPc = pc; badAddr = ba; badAddrValid = bv; curPriv = p;
    status = st; excDeleg = exm; intDeleg = inm; bkptEnable = en; dbgCauseIn = dc;
    trapValid = 1'b1;
    @(negedge clk);
    trapValid = 1'b0;
  endtask

  task automatic expectNormal(input logic [15:0] c, input logic [15:0] pc, input logic [15:0] ba,
                              input logic bv, input logic [1:0] p, input logic [15:0] st, input bit toS);
    chk("R7/R10 pcWe", 32'(pcWe), 1);
    chk("R7/R10 pcNext", 32'(pcNext), 32'(toS ? SVEC : MVEC));
    chk("R6 privNext", 32'(privNext), toS ? 1 : 3);
    chk("R6 sTrapWe", 32'(sTrapWe), 32'(toS));
    chk("R6 mTrapWe", 32'(mTrapWe), 32'(!toS));
    chk("R9/R10 statusNext", 32'(statusNext), 32'(expStack(st, p, toS)));
    chk("R11 resvClear", 32'(resvClear), 1);
    chk("R2 no dbgEntry", 32'(dbgEntryWe), 0);
    chk("R8 sBadWe", 32'(sBadWe), 32'(toS && bv));
    chk("R8 mBadWe", 32'(mBadWe), 32'(!toS && bv));
    if (toS) begin
      chk("R7 sCause", 32'(sCauseOut), 32'(c));
      chk("R7 sEpc", 32'(sEpcOut), 32'(pc));
      if (bv) chk("R8 sBad", 32'(sBadOut), 32'(ba));
    end else begin
      chk("R10 mCause", 32'(mCauseOut), 32'(c));
      chk("R10 mEpc", 32'(mEpcOut), 32'(pc));
      if (bv) chk("R8 mBad", 32'(mBadOut), 32'(ba));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset strobes", 32'(strobes()), 32'h0);
    @(negedge clk);
    chk("R1 reset strobes held", 32'(strobes()), 32'h0);

    // Sweep: R3, R5, R6, R7, R8, R9, R10, R11
    for (int p = 0; p < 4; p++)
      for (int intr = 0; intr < 2; intr++)
        for (int num = 0; num < 20; num++)
          for (int pat = 0; pat < 4; pat++) begin
            logic [15:0] exm, inm, c, pc, ba, st, msk;
            logic bv, bitv;
            bit toS;
            case (pat)
              0: begin exm = 16'h0000; inm = 16'h0000; end
              1: begin exm = 16'hFFFF; inm = 16'hFFFF; end
              2: begin exm = 16'h9A56; inm = 16'h65A9; end
              default: begin exm = 16'hFFFF; inm = 16'h0000; end
            endcase
            c   = {intr[0], 15'(num)};
            pc  = 16'(16'h1000 + p * 16'h0100 + num * 4 + pat);
            ba  = 16'(16'hB000 + num * 16'h11 + pat);
            st  = 16'(16'hA5C3 ^ (num * 16'h0137) ^ (p << 9) ^ (pat << 4));
            bv  = 1'((num + pat) % 2);
            msk = intr ? inm : exm;
            bitv = (num < 16) ? msk[num] : 1'b0;
            toS = (p <= 1) && bitv;
            fire(c, pc, ba, bv, 2'(p), st, exm, inm, 4'h0, 3'd0);
            expectNormal(c, pc, ba, bv, 2'(p), st, toS);
          end

    // Breakpoint sweep: R2, R3, R4
    for (int en = 0; en < 16; en++)
      for (int p = 0; p < 4; p++)
        for (int dc = 0; dc < 2; dc++) begin
          logic [15:0] pc, st;
          logic hit;
          pc = 16'(16'h2000 + en * 16'h40 + p * 4 + dc);
          st = 16'(16'h0F0F ^ (en << 4) ^ p);
          hit = en[p];
          fire(16'd3, pc, 16'hDEAD, 1'b1, 2'(p), st, 16'h0000, 16'h0000, 4'(en), dc ? 3'd2 : 3'd0);
          if (hit) begin
            chk("R2 pcNext", 32'(pcNext), 32'(DSTART));
            chk("R2 privNext", 32'(privNext), 3);
            chk("R2 dbgEntryWe", 32'(dbgEntryWe), 1);
            chk("R2 dbgCause", 32'(dbgCauseOut), 1);
            chk("R2 dbgPriv", 32'(dbgPrivOut), 32'(p));
            chk("R2 dpc", 32'(dpcOut), 32'(pc));
            chk("R2 no other writes", 32'({statusWe, sTrapWe, mTrapWe, sBadWe, mBadWe, resvClear}), 0);
          end else if (dc) begin
            chk("R4 pcWe", 32'(pcWe), 1);
            chk("R4 pcNext", 32'(pcNext), 32'(DEXC));
            chk("R4 only pc", 32'(strobes()), 32'h100);
          end else begin
            expectNormal(16'd3, pc, 16'hDEAD, 1'b1, 2'(p), st, 1'b0);
          end
        end

    // R4: interrupt and delegable exception inside debug mode
    fire(16'h8001, 16'h3000, 16'h0, 1'b0, 2'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'h0, 3'd4);
    chk("R4 irq in debug", 32'(strobes()), 32'h100);
    chk("R4 irq pcNext", 32'(pcNext), 32'(DEXC));
    fire(16'h0005, 16'h3004, 16'h1, 1'b1, 2'd1, 16'h0, 16'hFFFF, 16'hFFFF, 4'hF, 3'd1);
    chk("R4 exc in debug", 32'(strobes()), 32'h100);

    // R12: strobes last a single cycle
    fire(16'h0002, 16'h3010, 16'h0, 1'b0, 2'd3, 16'h0008, 16'h0, 16'h0, 4'h0, 3'd0);
    chk("R12 strobe on", 32'(mTrapWe), 1);
    @(negedge clk);
    chk("R12 strobe one cycle", 32'(strobes()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule